// File: doc/BRIEF.md
# Supply Supervisor Reset and Warning Control

This block is the clocked decision logic that sits behind a set of supply-voltage comparators. It receives five already-digitized "supply is below threshold" indications: one for the power-on threshold, two for the low-voltage detect trips (a low one and a high one) and two for the warning trips. From these, and from a handful of configuration bits, it drives the chip reset. It can also raise a sticky detect flag with an interrupt request, and it reports a warning flag, sticky reset-cause bits and whether the deepest stop mode may be entered.

The power-on comparator clears every register at once, with or without a clock, and the reset then lasts until the low detect trip reads clear. Once running, the detector is armed by an enable bit. A level-select bit picks which detect trip counts. A low supply either holds the chip in reset until the chosen trip clears, or sets the flag for software. In stop modes the detector sleeps unless a keep-alive bit is set, and with that bit and the enable both set the deepest stop is refused.

Top module: `supply_guard`

## Requirements
- R1: While `porBelow` is 1, `chipRst` is 1 at once, with no clock edge needed. The same condition loads `srcPor`=1, `srcLvd`=1, `detFlag`=0 and `warnFlag`=1.
- R2: After `porBelow` falls, `chipRst` stays 1 until `cmpLowDet` reads 0, whatever `detLvlHigh` holds. It falls on the third rising edge after `cmpLowDet` goes to 0 (two synchronizer flops plus the registered reset).
- R3: The detector is armed only when `detEn`=1 and either `stopActive`=0 or `stopKeepEn`=1. While it is disarmed, a low supply changes neither `chipRst` nor `detFlag`.
- R4: The selected detect comparator is `cmpHighDet` when `detLvlHigh`=1 and `cmpLowDet` otherwise. When the detector is armed, `rstEn`=1 and that comparator is 1, `chipRst` rises on the third edge after the comparator changes. It stays 1 until the selected comparator reads 0, again with a three-edge latency.
- R5: `srcLvd` is set on the edge where a low-voltage reset ends. Entering or holding that reset does not clear it. A 1 on `srcAck[1]` clears it, but a set on the same edge wins.
- R6: When the detector is armed and `rstEn`=0, a low supply sets `detFlag` with a three-edge latency. The flag is sticky. `flagAck` clears it only on an edge where no low condition is present.
- R7: `irqReq` is `detFlag` AND `irqEn`.
- R8: `warnFlag` follows `cmpHighWarn` when `warnLvlHigh`=1 and `cmpLowWarn` otherwise, with a three-edge latency. It never affects `irqReq`.
- R9: `stop2Allowed` is 0 exactly when `detEn` and `stopKeepEn` are both 1. It changes without a clock edge.
- R10: A 1 on `srcAck[0]` clears `srcPor` on the next edge. Only the power-on condition sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| porBelow | input | 1 | Supply below power-on threshold; asynchronous reset of the block |
| cmpLowDet | input | 1 | Supply below low detect trip |
| cmpHighDet | input | 1 | Supply below high detect trip |
| cmpLowWarn | input | 1 | Supply below low warning trip |
| cmpHighWarn | input | 1 | Supply below high warning trip |
| detEn | input | 1 | Detector enable |
| detLvlHigh | input | 1 | 1 selects the high detect trip |
| rstEn | input | 1 | Low supply causes reset (else flag) |
| irqEn | input | 1 | Interrupt enable for the detect flag |
| stopKeepEn | input | 1 | Keep detector armed in stop modes |
| warnLvlHigh | input | 1 | 1 selects the high warning trip |
| stopActive | input | 1 | Chip is in a stop mode |
| flagAck | input | 1 | Acknowledge strobe for the detect flag |
| srcAck | input | 2 | Write-one clear: bit 0 power-on cause, bit 1 low-voltage cause |
| chipRst | output | 1 | Chip reset, active high |
| irqReq | output | 1 | Interrupt request |
| detFlag | output | 1 | Sticky low-voltage detect flag |
| warnFlag | output | 1 | Low-voltage warning flag |
| srcPor | output | 1 | Sticky power-on reset cause |
| srcLvd | output | 1 | Sticky low-voltage reset cause |
| stop2Allowed | output | 1 | Deepest stop mode may be entered |

## Verification
The assertions check the following on every cycle:
- The power-on hold does not end while the synchronized low-detect input still reads below.
- The detect flag survives an acknowledge while a fault is present.
- The low-voltage cause bit is set when a low-voltage reset ends and stays set until it is acknowledged.
- The interrupt request never appears without the flag.
- The deepest stop is refused only for the enable-plus-keep-alive combination.

Only the bench scenarios can show the following:
- The exact three-edge latencies.
- That power-on release ignores the level select.
- That disarming in stop modes really suppresses both reset and flag.
- That the warning follows its own select without touching the interrupt.

// File: rtl/supply_guard_pkg.sv
package supply_guard_pkg;

  localparam int CMP_COUNT = 4;
  localparam int IDX_LOW_DET = 0;
  localparam int IDX_HIGH_DET = 1;
  localparam int IDX_LOW_WARN = 2;
  localparam int IDX_HIGH_WARN = 3;

  typedef enum logic [1:0] {
    ST_RUN      = 2'd0,
    ST_HOLD_POR = 2'd1,
    ST_HOLD_LVD = 2'd2
  } guardState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic setLvdSrc;
    logic setDetFlag;
  } ctrlStrobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic lowDetBelow;
    logic selDetBelow;
    logic fault;
  } dpStatus_t;

endpackage

// File: rtl/supply_guard_sync.sv
module supply_guard_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             arst,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] stageQ;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      stageQ <= {STAGES{RST_VAL}};
    end else begin
      stageQ[0] <= dIn;
      for (int i = 1; i < STAGES; i++) begin
        stageQ[i] <= stageQ[i-1];
      end
    end
  end

  assign dOut = stageQ[LAST];

endmodule

// File: rtl/supply_guard_dp.sv
module supply_guard_dp
  import supply_guard_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 arst,
  input  logic [CMP_COUNT-1:0] cmpBelow,
  input  logic                 detEn,
  input  logic                 detLvlHigh,
  input  logic                 stopActive,
  input  logic                 stopKeepEn,
  input  logic                 warnLvlHigh,
  input  logic                 flagAck,
  input  logic [1:0]           srcAck,
  input  ctrlStrobe_t          strobe,
  output dpStatus_t            status,
  output logic                 detFlag,
  output logic                 warnFlag,
  output logic                 srcPor,
  output logic                 srcLvd
);

  logic [CMP_COUNT-1:0] cmpSync;
  logic detArmed;
  logic warnSel;

  supply_guard_sync #(
    .WIDTH  (CMP_COUNT),
    .STAGES (SYNC_STAGES),
    .RST_VAL({CMP_COUNT{1'b1}})
  ) i_sync (
    .clk (clk),
    .arst(arst),
    .dIn (cmpBelow),
    .dOut(cmpSync)
  );

  assign detArmed = detEn && (!stopActive || stopKeepEn);

  always_comb begin
    status.lowDetBelow = cmpSync[IDX_LOW_DET];
    status.selDetBelow = detLvlHigh ? cmpSync[IDX_HIGH_DET] : cmpSync[IDX_LOW_DET];
    status.fault       = detArmed && status.selDetBelow;
  end

  assign warnSel = warnLvlHigh ? cmpSync[IDX_HIGH_WARN] : cmpSync[IDX_LOW_WARN];

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      detFlag  <= 1'b0;
      warnFlag <= 1'b1;
      srcPor   <= 1'b1;
      srcLvd   <= 1'b1;
    end else begin
      warnFlag <= warnSel;
      if (strobe.setDetFlag) begin
        detFlag <= 1'b1;
      end else if (flagAck && !status.fault) begin
        detFlag <= 1'b0;
      end
      if (srcAck[0]) begin
        srcPor <= 1'b0;
      end
      if (strobe.setLvdSrc) begin
        srcLvd <= 1'b1;
      end else if (srcAck[1]) begin
        srcLvd <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/supply_guard_ctrl.sv
module supply_guard_ctrl
  import supply_guard_pkg::*;
(
  input  logic        clk,
  input  logic        arst,
  input  dpStatus_t   status,
  input  logic        rstEn,
  output ctrlStrobe_t strobe,
  output logic        chipRst,
  output guardState_e stateOut
);

  guardState_e stateQ;
  logic rstQ;

  always_comb begin
    strobe.setDetFlag = (stateQ == ST_RUN) && status.fault && !rstEn;
    strobe.setLvdSrc  = (stateQ == ST_HOLD_LVD) && !status.selDetBelow;
  end

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      stateQ <= ST_HOLD_POR;
      rstQ   <= 1'b1;
    end else begin
      case (stateQ)
        ST_HOLD_POR: begin
          if (!status.lowDetBelow) begin
            stateQ <= ST_RUN;
            rstQ   <= 1'b0;
          end
        end
        ST_RUN: begin
          if (status.fault && rstEn) begin
            stateQ <= ST_HOLD_LVD;
            rstQ   <= 1'b1;
          end
        end
        ST_HOLD_LVD: begin
          if (!status.selDetBelow) begin
            stateQ <= ST_RUN;
            rstQ   <= 1'b0;
          end
        end
        default: begin
          stateQ <= ST_HOLD_POR;
          rstQ   <= 1'b1;
        end
      endcase
    end
  end

  assign chipRst  = rstQ;
  assign stateOut = stateQ;

endmodule

// File: rtl/supply_guard.sv
module supply_guard
  import supply_guard_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       porBelow,
  input  logic       cmpLowDet,
  input  logic       cmpHighDet,
  input  logic       cmpLowWarn,
  input  logic       cmpHighWarn,
  input  logic       detEn,
  input  logic       detLvlHigh,
  input  logic       rstEn,
  input  logic       irqEn,
  input  logic       stopKeepEn,
  input  logic       warnLvlHigh,
  input  logic       stopActive,
  input  logic       flagAck,
  input  logic [1:0] srcAck,
  output logic       chipRst,
  output logic       irqReq,
  output logic       detFlag,
  output logic       warnFlag,
  output logic       srcPor,
  output logic       srcLvd,
  output logic       stop2Allowed
);

  logic [CMP_COUNT-1:0] cmpVec;
  ctrlStrobe_t ctrlStb;
  dpStatus_t   dpStat;
  guardState_e ctrlState;

  always_comb begin
    cmpVec = '0;
    cmpVec[IDX_LOW_DET]   = cmpLowDet;
    cmpVec[IDX_HIGH_DET]  = cmpHighDet;
    cmpVec[IDX_LOW_WARN]  = cmpLowWarn;
    cmpVec[IDX_HIGH_WARN] = cmpHighWarn;
  end

  supply_guard_dp #(
    .SYNC_STAGES(SYNC_STAGES)
  ) i_dp (
    .clk        (clk),
    .arst       (porBelow),
    .cmpBelow   (cmpVec),
    .detEn      (detEn),
    .detLvlHigh (detLvlHigh),
    .stopActive (stopActive),
    .stopKeepEn (stopKeepEn),
    .warnLvlHigh(warnLvlHigh),
    .flagAck    (flagAck),
    .srcAck     (srcAck),
    .strobe     (ctrlStb),
    .status     (dpStat),
    .detFlag    (detFlag),
    .warnFlag   (warnFlag),
    .srcPor     (srcPor),
    .srcLvd     (srcLvd)
  );

  supply_guard_ctrl i_ctrl (
    .clk     (clk),
    .arst    (porBelow),
    .status  (dpStat),
    .rstEn   (rstEn),
    .strobe  (ctrlStb),
    .chipRst (chipRst),
    .stateOut(ctrlState)
  );

  assign irqReq       = detFlag & irqEn;
  assign stop2Allowed = ~(detEn & stopKeepEn);

endmodule

// File: rtl/supply_guard_chk.sv
module supply_guard_chk
  import supply_guard_pkg::*;
(
  input logic        clk,
  input logic        porBelow,
  input logic        chipRst,
  input logic        irqReq,
  input logic        irqEn,
  input logic        detFlag,
  input logic        flagAck,
  input logic        srcLvd,
  input logic [1:0]  srcAck,
  input logic        stop2Allowed,
  input logic        detEn,
  input logic        stopKeepEn,
  input guardState_e ctrlState,
  input dpStatus_t   dpStat
);

  AST_POR_HOLD_WHILE_LOW: assert property (@(posedge clk) disable iff (porBelow)
    (ctrlState == ST_HOLD_POR && dpStat.lowDetBelow) |=> chipRst); // R2

  AST_FLAG_KEPT_UNACKED: assert property (@(posedge clk) disable iff (porBelow)
    (detFlag && !flagAck) |=> detFlag); // R6

  AST_FLAG_KEPT_IN_FAULT: assert property (@(posedge clk) disable iff (porBelow)
    (detFlag && dpStat.fault) |=> detFlag); // R6

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (porBelow)
    irqReq |-> (detFlag && irqEn)); // R7

  AST_LVD_SRC_ON_RELEASE: assert property (@(posedge clk) disable iff (porBelow)
    ($fell(chipRst) && $past(ctrlState) == ST_HOLD_LVD) |-> srcLvd); // R5

  AST_LVD_SRC_STICKY: assert property (@(posedge clk) disable iff (porBelow)
    (srcLvd && !srcAck[1]) |=> srcLvd); // R5

  AST_STOP2_REFUSAL: assert property (@(posedge clk) disable iff (porBelow)
    !stop2Allowed |-> (detEn && stopKeepEn)); // R9

endmodule

bind supply_guard supply_guard_chk i_chk (
  .clk         (clk),
  .porBelow    (porBelow),
  .chipRst     (chipRst),
  .irqReq      (irqReq),
  .irqEn       (irqEn),
  .detFlag     (detFlag),
  .flagAck     (flagAck),
  .srcLvd      (srcLvd),
  .srcAck      (srcAck),
  .stop2Allowed(stop2Allowed),
  .detEn       (detEn),
  .stopKeepEn  (stopKeepEn),
  .ctrlState   (ctrlState),
  .dpStat      (dpStat)
);

// File: tb/test_supply_guard.sv
`timescale 1ns/1ps
module test_supply_guard;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic porBelow, cmpLowDet, cmpHighDet, cmpLowWarn, cmpHighWarn;
  logic detEn, detLvlHigh, rstEn, irqEn, stopKeepEn, warnLvlHigh, stopActive, flagAck;
  logic [1:0] srcAck;
  logic chipRst, irqReq, detFlag, warnFlag, srcPor, srcLvd, stop2Allowed;

  int checks = 0;
  int errors = 0;
  int level;

  supply_guard i_supply_guard (
    .clk(clk), .porBelow(porBelow), .cmpLowDet(cmpLowDet), .cmpHighDet(cmpHighDet),
    .cmpLowWarn(cmpLowWarn), .cmpHighWarn(cmpHighWarn), .detEn(detEn),
    .detLvlHigh(detLvlHigh), .rstEn(rstEn), .irqEn(irqEn), .stopKeepEn(stopKeepEn),
    .warnLvlHigh(warnLvlHigh), .stopActive(stopActive), .flagAck(flagAck),
    .srcAck(srcAck), .chipRst(chipRst), .irqReq(irqReq), .detFlag(detFlag),
    .warnFlag(warnFlag), .srcPor(srcPor), .srcLvd(srcLvd), .stop2Allowed(stop2Allowed)
  );

  // expectation state built from the requirements
  logic [3:0] m1, m2;
  int  mSt;            // 0 run, 1 power-on hold, 2 low-voltage hold
  logic mRst, mFlag, mPor, mLvd, mWarn;

  task automatic modelReset();
    m1 = 4'hF; m2 = 4'hF; mSt = 1; mRst = 1'b1;
    mFlag = 1'b0; mPor = 1'b1; mLvd = 1'b1; mWarn = 1'b1;
  endtask

  function automatic logic [3:0] cmpFromLevel(input int lvl);
    return {lvl < 5, lvl < 4, lvl < 3, lvl < 2};
  endfunction

  task automatic modelStep();
    logic armed, sel, fault, setLvd, setFlag;
    int nSt;
    logic nRst;
    if (porBelow) begin
      modelReset();
      return;
    end
    armed   = detEn && (!stopActive || stopKeepEn);
    sel     = detLvlHigh ? m2[1] : m2[0];
    fault   = armed && sel;
    setLvd  = 1'b0;
    nSt     = mSt;
    nRst    = mRst;
    setFlag = (mSt == 0) && fault && !rstEn;
    if (mSt == 1 && !m2[0]) begin nSt = 0; nRst = 1'b0; end
    else if (mSt == 0 && fault && rstEn) begin nSt = 2; nRst = 1'b1; end
    else if (mSt == 2 && !sel) begin nSt = 0; nRst = 1'b0; setLvd = 1'b1; end
    if (setFlag) mFlag = 1'b1;
    else if (flagAck && !fault) mFlag = 1'b0;
    if (srcAck[0]) mPor = 1'b0;
    if (setLvd) mLvd = 1'b1;
    else if (srcAck[1]) mLvd = 1'b0;
    mWarn = warnLvlHigh ? m2[3] : m2[2];
    mSt = nSt;
    mRst = nRst;
    m2 = m1;
    m1 = {cmpHighWarn, cmpLowWarn, cmpHighDet, cmpLowDet};
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    chk("R1/R2/R4 chipRst", chipRst, mRst);
    chk("R6 detFlag", detFlag, mFlag);
    chk("R7 irqReq", irqReq, mFlag & irqEn);
    chk("R8 warnFlag", warnFlag, mWarn);
    chk("R10 srcPor", srcPor, mPor);
    chk("R5 srcLvd", srcLvd, mLvd);
    chk("R9 stop2Allowed", stop2Allowed, !(detEn && stopKeepEn));
  endtask

  task automatic setLevel(input int lvl);
    logic [3:0] c;
    level = lvl;
    c = cmpFromLevel(lvl);
    {cmpHighWarn, cmpLowWarn, cmpHighDet, cmpLowDet} = c;
  endtask

  // one clock: inputs are stable across the edge, outputs compared at the negedge
  task automatic cycle();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    porBelow = 1'b1; setLevel(0);
    detEn = 0; detLvlHigh = 0; rstEn = 0; irqEn = 0; stopKeepEn = 0;
    warnLvlHigh = 0; stopActive = 0; flagAck = 0; srcAck = 2'b00;
    modelReset();
    #1;
    // R1: asynchronous reset state before any clock edge
    chk("R1 chipRst at power-on", chipRst, 1'b1);
    chk("R1 srcPor at power-on", srcPor, 1'b1);
    chk("R1 srcLvd at power-on", srcLvd, 1'b1);
    chk("R1 detFlag at power-on", detFlag, 1'b0);
    @(negedge clk);
    cycles(3);

    // R2: release waits for the low trip even with the high trip selected
    detLvlHigh = 1; setLevel(2); porBelow = 1'b0;
    cycles(2);
    chk("R2 reset still held", chipRst, 1'b1);
    cycle();
    chk("R2 reset released on low trip", chipRst, 1'b0);
    cycles(2);

    // R10 and R5: write-one clears of the cause bits
    setLevel(5); srcAck = 2'b11;
    cycle();
    srcAck = 2'b00;
    chk("R10 srcPor cleared", srcPor, 1'b0);
    chk("R5 srcLvd cleared", srcLvd, 1'b0);
    cycles(3);

    // R4: low-voltage reset on the high trip, held until it clears
    detEn = 1; rstEn = 1; detLvlHigh = 1; setLevel(2);
    cycles(2);
    chk("R4 no reset yet", chipRst, 1'b0);
    cycle();
    chk("R4 reset asserted", chipRst, 1'b1);
    chk("R5 srcLvd not set on entry", srcLvd, 1'b0);
    setLevel(3);
    cycles(2);
    chk("R4 reset held", chipRst, 1'b1);
    cycle();
    chk("R4 reset released", chipRst, 1'b0);
    chk("R5 srcLvd set on release", srcLvd, 1'b1);
    chk("R10 srcPor stays clear", srcPor, 1'b0);

    // R6/R7: flag mode
    rstEn = 0; irqEn = 1; setLevel(2);
    cycles(3);
    chk("R6 detFlag set", detFlag, 1'b1);
    chk("R7 irqReq raised", irqReq, 1'b1);
    flagAck = 1;
    cycle();
    flagAck = 0;
    chk("R6 ack ignored in fault", detFlag, 1'b1);
    setLevel(5);
    cycles(3);
    irqEn = 0;
    #1;
    chk("R7 irqReq masked", irqReq, 1'b0);
    flagAck = 1;
    cycle();
    flagAck = 0;
    chk("R6 ack clears flag", detFlag, 1'b0);

    // R3/R9: stop-mode disarm and stop2 refusal
    irqEn = 1; rstEn = 1; detLvlHigh = 0; stopActive = 1; stopKeepEn = 0; setLevel(1);
    #1;
    chk("R9 stop2 allowed", stop2Allowed, 1'b1);
    cycles(5);
    chk("R3 disarmed no reset", chipRst, 1'b0);
    chk("R3 disarmed no flag", detFlag, 1'b0);
    stopKeepEn = 1;
    #1;
    chk("R9 stop2 refused", stop2Allowed, 1'b0);
    cycle();
    chk("R3 kept armed in stop", chipRst, 1'b1);
    setLevel(5); stopActive = 0; stopKeepEn = 0;
    cycles(4);

    // R8: warning select, no interrupt
    detEn = 0; irqEn = 1; warnLvlHigh = 0; setLevel(4);
    cycles(3);
    chk("R8 low warn clear", warnFlag, 1'b0);
    warnLvlHigh = 1;
    cycle();
    chk("R8 high warn set", warnFlag, 1'b1);
    chk("R8 no irq from warn", irqReq, 1'b0);

    // constrained random phase
    void'($urandom(32'h5EED_2024));
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 7) == 0) setLevel($urandom_range(1, 5));
      if ($urandom_range(0, 39) == 0) begin
        detEn = $urandom_range(0, 3) != 0; detLvlHigh = $urandom_range(0, 1);
        rstEn = $urandom_range(0, 1); irqEn = $urandom_range(0, 1);
        stopKeepEn = $urandom_range(0, 1); warnLvlHigh = $urandom_range(0, 1);
        stopActive = $urandom_range(0, 3) == 0;
      end
      flagAck = $urandom_range(0, 7) == 0;
      srcAck = ($urandom_range(0, 9) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
      if ($urandom_range(0, 499) == 0) begin
        porBelow = 1'b1; setLevel(0);
        #1;
        chk("R1 async reset mid-run", chipRst, 1'b1);
        cycles(2);
        setLevel($urandom_range(1, 5)); porBelow = 1'b0;
      end
      cycle();
    end
    summary();
  end

endmodule